// File: doc/BRIEF.md
# Two-Wire Slave with a 16-Bit Register Bank

This block lets a host on a two-wire serial bus (I2C-style, SCL and SDA) read and write a bank of 16-bit registers. Both lines are oversampled by a fast system clock. The block drives SDA only by pulling it low, through an output-enable pin. The surrounding logic combines this enable with an external pull-up.

Each bus transaction begins with a device ID. The ID is picked from four values by two strap pins. It is followed by a one-byte register pointer. Each register is sent as two bytes, high byte first, and the pointer advances after every full 16-bit word in either direction.

A reserved alias pointer gives byte-wide access to the low half of a register. A write to the alias merges the byte with the most recent high byte and puts the result in that byte's register. A read of the alias returns the low byte that was captured when the most recent high byte was read.

Top module: `twi_reg16_slave`

## Requirements
- R1: The 8-bit ID is 0x90 with bit 3 set by `strap_i[0]` and bit 5 set by `strap_i[1]`; bit 0 of the ID byte is the direction (0 write, 1 read). A matching ID is acknowledged by pulling SDA low during the ninth SCL pulse.
- R2: A non-matching ID gets no acknowledge. The block then leaves SDA released for every later byte until the next start condition.
- R3: In a write, the block acknowledges the register pointer byte and every data byte.
- R4: Write data is taken high byte first, then low byte. The register is updated when the low byte arrives, and the pointer then rises by one, wrapping from 0xFF to 0x00.
- R5: A read is a write-mode ID plus pointer, then a repeated start, then a read-mode ID. The block then returns the high byte and then the low byte of each register, and the pointer rises by one per word.
- R6: A no-acknowledge from the host after a read byte ends the read. SDA stays released until the next start.
- R7: A write that ends after only the high byte of a word leaves that register unchanged.
- R8: A byte written at pointer 0xF0 becomes the low half of the register that last received a high byte, with that high byte as its upper half. Alias accesses never move the pointer.
- R9: Reading only the high byte of a register captures its low byte. Each read at pointer 0xF0 returns that captured byte.
- R10: After reset and after a stop condition, SDA is released. The SDA enable changes only while the synchronized SCL is low.
- R11: A start condition ends any write in progress and returns the block to receiving a device ID. The pointer is kept across the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| strap_i | input | 2 | ID strap pins: bit 0 sets ID bit 3, bit 1 sets ID bit 5 |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |

## Verification
The two functions that can meet in one cycle are the write or read strobe and a change of the register pointer. A low-byte commit advances the pointer in the same cycle that the word lands, and the alias path writes a register other than the one the pointer names. The bench covers this with long bursts that cross the pointer wrap and with alias writes placed right after a high-byte-only write. It then reads every affected word back and compares it with a value computed from its address.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } twi_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_REG,
    RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic              scl_prev_q, sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_o;
      sda_prev_q <= sda_o;
    end
  end

  assign scl_o      = scl_pipe_q[STAGES-1];
  assign sda_o      = sda_pipe_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  // data edge while clock stays high
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/twi_regs.sv
module twi_regs #(
  parameter int                REG_AW     = 8,
  parameter logic [REG_AW-1:0] ALIAS_ADDR = REG_AW'(8'hF0)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sess_i,
  input  logic       ptr_stb_i,
  input  logic [7:0] ptr_byte_i,
  input  logic       wr_stb_i,
  input  logic [7:0] wr_byte_i,
  input  logic       rd_stb_i,
  output logic [7:0] rd_byte_o
);
  localparam int DEPTH = 1 << REG_AW;

  logic [15:0]       mem_q [DEPTH];
  logic [REG_AW-1:0] ptr_q, hi_addr_q;
  logic [7:0]        hi_sh_q, lo_sh_q;
  logic              phase_q;
  logic              is_alias;

  assign is_alias = (ptr_q == ALIAS_ADDR);

  always_comb begin
    if (is_alias || phase_q) rd_byte_o = lo_sh_q;
    else                     rd_byte_o = mem_q[ptr_q][15:8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      ptr_q     <= '0;
      hi_addr_q <= '0;
      hi_sh_q   <= '0;
      lo_sh_q   <= '0;
      phase_q   <= 1'b0;
    end else if (sess_i) begin
      phase_q <= 1'b0;
    end else if (ptr_stb_i) begin
      ptr_q   <= ptr_byte_i[REG_AW-1:0];
      phase_q <= 1'b0;
    end else if (wr_stb_i) begin
      if (is_alias) begin
        mem_q[hi_addr_q] <= {hi_sh_q, wr_byte_i};
      end else if (!phase_q) begin
        hi_sh_q   <= wr_byte_i;
        hi_addr_q <= ptr_q;
        phase_q   <= 1'b1;
      end else begin
        mem_q[ptr_q] <= {hi_sh_q, wr_byte_i};
        phase_q      <= 1'b0;
        ptr_q        <= ptr_q + 1'b1;
      end
    end else if (rd_stb_i && !is_alias) begin
      if (!phase_q) begin
        lo_sh_q <= mem_q[ptr_q][7:0];
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        ptr_q   <= ptr_q + 1'b1;
      end
    end
  end

  // R8
  alias_ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i || rd_stb_i) && is_alias |=> $stable(ptr_q));
  // R4
  word_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i && !is_alias && phase_q |=> ptr_q == REG_AW'($past(ptr_q) + 1'b1));
endmodule

// File: rtl/twi_proto.sv
module twi_proto
  import twi_pkg::*;
#(
  parameter logic [6:0] BASE_ID = 7'h48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_s_i,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [1:0] strap_i,
  input  logic [7:0] rd_byte_i,
  output logic       sess_o,
  output logic       ptr_stb_o,
  output logic       wr_stb_o,
  output logic       rd_stb_o,
  output logic [7:0] byte_o,
  output logic       sda_oe_o
);
  twi_state_e        state_q;
  rx_kind_e          kind_q, after_kind_q;
  logic              after_tx_q;
  logic [BYTE_W-1:0] sh_q;
  logic [2:0]        cnt_q;
  logic              got_q, mack_q, oe_q;
  logic [6:0]        id7;
  logic              dev_match, byte_evt, load_evt;

  assign id7       = BASE_ID | {2'b00, strap_i[1], 1'b0, strap_i[0], 2'b00};
  assign dev_match = (sh_q[7:1] == id7);
  assign byte_evt  = scl_fall_i && (state_q == ST_RX) && got_q && !start_i && !stop_i;
  assign load_evt  = scl_fall_i && !start_i && !stop_i &&
                     (((state_q == ST_ACK) && after_tx_q) || ((state_q == ST_RACK) && mack_q));

  assign sess_o    = start_i;
  assign ptr_stb_o = byte_evt && (kind_q == RX_REG);
  assign wr_stb_o  = byte_evt && (kind_q == RX_DATA);
  assign rd_stb_o  = load_evt;
  assign byte_o    = sh_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      kind_q       <= RX_DEV;
      after_kind_q <= RX_REG;
      after_tx_q   <= 1'b0;
      sh_q         <= '0;
      cnt_q        <= '0;
      got_q        <= 1'b0;
      mack_q       <= 1'b0;
      oe_q         <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_RX;
      kind_q  <= RX_DEV;
      cnt_q   <= '0;
      got_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[6:0], sda_s_i};
            cnt_q <= cnt_q + 1'b1;
            got_q <= (cnt_q == 3'd7);
          end else if (scl_fall_i && got_q) begin
            got_q <= 1'b0;
            if (kind_q == RX_DEV && !dev_match) begin
              state_q <= ST_IDLE;
            end else begin
              oe_q         <= 1'b1;
              state_q      <= ST_ACK;
              after_tx_q   <= (kind_q == RX_DEV) && sh_q[0];
              after_kind_q <= (kind_q == RX_DEV) ? RX_REG : RX_DATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            got_q <= 1'b0;
            if (after_tx_q) begin
              state_q <= ST_TX;
              sh_q    <= rd_byte_i;
              oe_q    <= ~rd_byte_i[7];
            end else begin
              state_q <= ST_RX;
              kind_q  <= after_kind_q;
              oe_q    <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 1'b1;
            got_q <= (cnt_q == 3'd7);
          end else if (scl_fall_i) begin
            if (got_q) begin
              got_q   <= 1'b0;
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              sh_q <= {sh_q[6:0], 1'b0};
              oe_q <= ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_s_i;
          end else if (scl_fall_i) begin
            cnt_q <= '0;
            got_q <= 1'b0;
            if (mack_q) begin
              state_q <= ST_TX;
              sh_q    <= rd_byte_i;
              oe_q    <= ~rd_byte_i[7];
            end else begin
              state_q <= ST_IDLE;
              oe_q    <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R10
  sda_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_s_i);
  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !oe_q);
  // R2
  id_miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_evt && (kind_q == RX_DEV) && !dev_match |=> !oe_q && state_q == ST_IDLE);
  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_stb_o, rd_stb_o, ptr_stb_o, sess_o}));
endmodule

// File: rtl/twi_reg16_slave.sv
module twi_reg16_slave #(
  parameter int                REG_AW      = 8,
  parameter logic [REG_AW-1:0] ALIAS_ADDR  = REG_AW'(8'hF0),
  parameter logic [6:0]        BASE_ID     = 7'h48,
  parameter int                SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       sess, ptr_stb, wr_stb, rd_stb;
  logic [7:0] bus_byte, rd_byte;

  twi_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  twi_proto #(.BASE_ID(BASE_ID)) i_proto (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .strap_i    (strap_i),
    .rd_byte_i  (rd_byte),
    .sess_o     (sess),
    .ptr_stb_o  (ptr_stb),
    .wr_stb_o   (wr_stb),
    .rd_stb_o   (rd_stb),
    .byte_o     (bus_byte),
    .sda_oe_o   (sda_oe_o)
  );

  twi_regs #(.REG_AW(REG_AW), .ALIAS_ADDR(ALIAS_ADDR)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sess_i     (sess),
    .ptr_stb_i  (ptr_stb),
    .ptr_byte_i (bus_byte),
    .wr_stb_i   (wr_stb),
    .wr_byte_i  (bus_byte),
    .rd_stb_i   (rd_stb),
    .rd_byte_o  (rd_byte)
  );
endmodule

// File: tb/test_twi_reg16_slave.sv
module test_twi_reg16_slave;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       sda_oe;
  logic       sda_line;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  twi_reg16_slave i_twi_reg16_slave (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .sda_oe_o (sda_oe)
  );

  function automatic logic [15:0] val(input logic [7:0] a);
    return {a, ~a} ^ 16'h5A3C;
  endfunction

  function automatic logic [7:0] dev_id(input logic [1:0] s, input logic rd);
    return 8'h90 | {2'b00, s[1], 1'b0, s[0], 3'b000} | {7'd0, rd};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b0; tick(H);
    scl = 1'b0;   tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(H);
    scl = 1'b1; tick(2 * H);
    scl = 1'b0; tick(H);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H);
    ack = ~sda_line;
    tick(H);
    scl = 1'b0;   tick(H);
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(H);
      scl = 1'b1;   tick(H);
      b[i] = sda_line;
      tick(H);
      scl = 1'b0;   tick(H);
    end
    send_bit(~mack);
  endtask

  task automatic open_write(input logic [7:0] a, output logic ok);
    logic k1, k2;
    bus_start();
    tx_byte(dev_id(strap, 1'b0), k1);
    tx_byte(a, k2);
    ok = k1 & k2;
  endtask

  task automatic open_read(input logic [7:0] a, output logic ok);
    logic k1, k2;
    open_write(a, k1);
    bus_start();
    tx_byte(dev_id(strap, 1'b1), k2);
    ok = k1 & k2;
  endtask

  task automatic read_word(input logic [7:0] a, output logic [15:0] w);
    logic ok;
    open_read(a, ok);
    rx_byte(1'b1, w[15:8]);
    rx_byte(1'b0, w[7:0]);
    bus_stop();
    check("R5 read acks", {15'd0, ok}, 16'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic        ok, k;
    logic [7:0]  b;
    logic [15:0] w;
    logic [7:0]  probes [8];
    probes = '{8'h90, 8'h98, 8'hB0, 8'hB8, 8'h92, 8'hA0, 8'h10, 8'h94};

    tick(3);
    check("R10 reset release", {15'd0, sda_oe}, 16'd0);
    rst_n = 1'b1;
    tick(4);

    // R1 / R2: ID matching under every strap setting
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      tick(2);
      for (int p = 0; p < 8; p++) begin
        logic exp_ack;
        exp_ack = (probes[p][7:1] == dev_id(2'(s), 1'b0)[7:1]);
        bus_start();
        tx_byte(probes[p], k);
        check("R1 id ack", {15'd0, k}, {15'd0, exp_ack});
        if (!exp_ack) begin
          tx_byte(8'h00, k);
          check("R2 ignored after miss", {15'd0, k}, 16'd0);
        end
        bus_stop();
        check("R10 stop release", {15'd0, sda_oe}, 16'd0);
      end
    end
    strap = 2'b11;
    tick(2);

    // R3 / R4: long word burst, then R5 readback
    open_write(8'h00, ok);
    for (int a = 0; a < 192; a++) begin
      tx_byte(val(8'(a)) >> 8, k);  ok &= k;
      tx_byte(val(8'(a)) & 16'hFF, k); ok &= k;
    end
    bus_stop();
    check("R3 burst acks", {15'd0, ok}, 16'd1);
    open_read(8'h00, ok);
    check("R5 read setup", {15'd0, ok}, 16'd1);
    for (int a = 0; a < 192; a++) begin
      rx_byte(1'b1, w[15:8]);
      rx_byte(a != 191, w[7:0]);
      check("R4 R5 burst word", w, val(8'(a)));
    end
    bus_stop();

    // R4: pointer wrap 0xFF -> 0x00
    open_write(8'hFE, ok);
    for (int a = 0; a < 3; a++) begin
      tx_byte(~val(8'(8'hFE + a)) >> 8, k);
      tx_byte(~val(8'(8'hFE + a)) & 16'hFF, k);
    end
    bus_stop();
    open_read(8'hFE, ok);
    for (int a = 0; a < 3; a++) begin
      rx_byte(1'b1, w[15:8]);
      rx_byte(a != 2, w[7:0]);
      check("R4 wrap word", w, ~val(8'(8'hFE + a)));
    end
    bus_stop();
    read_word(8'h01, w);
    check("R4 no spill", w, val(8'h01));

    // R7: high byte then stop
    open_write(8'h40, ok);
    tx_byte(8'h77, k);
    bus_stop();
    read_word(8'h40, w);
    check("R7 partial stop", w, val(8'h40));

    // R11: high byte then repeated start, new write
    open_write(8'h41, ok);
    tx_byte(8'h66, k);
    open_write(8'h42, ok);
    tx_byte(8'hBE, k);
    tx_byte(8'hEF, k);
    bus_stop();
    check("R11 restart acks", {15'd0, ok}, 16'd1);
    read_word(8'h41, w);
    check("R11 partial restart", w, val(8'h41));
    read_word(8'h42, w);
    check("R11 write after restart", w, 16'hBEEF);

    // R8: byte write through alias
    open_write(8'h50, ok);
    tx_byte(8'h12, k);
    bus_stop();
    open_write(8'hF0, ok);
    tx_byte(8'h34, k);
    check("R8 alias ack", {15'd0, k}, 16'd1);
    bus_stop();
    read_word(8'h50, w);
    check("R8 alias merge", w, 16'h1234);
    open_write(8'hF0, ok);
    tx_byte(8'hA1, k);
    tx_byte(8'h56, k);
    bus_stop();
    read_word(8'h50, w);
    check("R8 alias no advance", w, 16'h1256);
    read_word(8'h51, w);
    check("R8 neighbour untouched", w, val(8'h51));

    // R9: high byte read, then alias twice
    open_read(8'h20, ok);
    rx_byte(1'b0, b);
    check("R9 high byte", {8'h00, b}, {8'h00, val(8'h20) >> 8});
    // R6: after nack the slave stays off the line
    rx_byte(1'b0, b);
    check("R6 released after nack", {8'h00, b}, 16'h00FF);
    bus_stop();
    open_read(8'hF0, ok);
    rx_byte(1'b1, b);
    check("R9 alias low byte", {8'h00, b}, val(8'h20) & 16'hFF);
    rx_byte(1'b0, b);
    check("R9 alias repeat", {8'h00, b}, val(8'h20) & 16'hFF);
    bus_stop();
    check("R10 idle after stop", {15'd0, sda_oe}, 16'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule